// File: doc/BRIEF.md
# Character-Cell Text Display Generator

This block turns a 50 MHz board clock into a 640x480, 60 Hz raster with active-low horizontal and vertical sync. A clock enable at half the board rate sets the pixel pace, and the divided pixel clock is also brought out as a pin. Free-running 10-bit column and row counters are exposed, so neighbouring logic can follow the beam.

The top-left corner of the screen holds a text window of character cells, 20 columns by 6 rows by default. Each cell stores a 4-bit code. A host writes a cell by giving its row, its column and the code. During scan, each cell code is turned into a 6-bit glyph address. An 8x8 font is then read at that address, and the dot bit picks the 3-3-2 foreground colour or black.

Cell read, glyph mapping and font read form a pipeline three pixels deep. Sync is delayed by the same amount, so it stays aligned with the colour output.

Top module: `txt_display_gen`

## Requirements
- R1: Counters and all pixel outputs change only once per two board clocks. `pix_clk_o` toggles on every board clock, and the outputs are updated on the edges where it was high.
- R2: `pix_col_o` counts from 0 to H_TOTAL-1 (800 by default) and then wraps to 0. At that wrap `pix_row_o` advances, and it wraps to 0 after V_TOTAL-1 (525 by default).
- R3: `hsync_no` is low for the pixels whose column lies in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC). `vsync_no` is low for rows in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC). Both appear three pixel periods after the counter values they belong to.
- R4: A lit dot drives red=`fg_color_i[7:5]`, green=`fg_color_i[4:2]` and blue=`fg_color_i[1:0]`. An unlit dot drives zero. The latency from the counters is three pixel periods.
- R5: The colour outputs are zero outside the visible area. They are also zero outside the text window, which covers columns below TXT_COLS*8 and rows below TXT_ROWS*8.
- R6: A write with `wr_en_i` high, `wr_row_i` < TXT_ROWS and `wr_col_i` < TXT_COLS stores `wr_code_i` in that cell. The cell is drawn at pixel columns col*8 to col*8+7 and pixel rows row*8 to row*8+7. Font row = pixel row mod 8, and font column c = pixel column mod 8 selects bit 7-c of the glyph row byte.
- R7: A write whose row or column is out of range changes no cell.
- R8: Codes 0 to 9 draw a segment digit. The segment masks (bit0=a … bit6=g) are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Glyph rows, top to bottom, are: 3C if a; 20|04 for f|b, twice; 3C if g; 20|04 for e|c, twice; 3C if d; 00.
- R9: Code 10 draws the letter glyph with rows 18, 3C, 66, 7E, 66, 66, 66, 00.
- R10: Codes 11 to 15 draw a blank glyph.
- R11: During reset, both syncs are high, the colour outputs are zero and the counters are zero. Every cell is reset to code 15, which is blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz board clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Cell write strobe |
| wr_row_i | input | 6 | Cell row of the write |
| wr_col_i | input | 6 | Cell column of the write |
| wr_code_i | input | 4 | Code written to the cell |
| fg_color_i | input | 8 | Foreground colour, 3-3-2 |
| pix_clk_o | output | 1 | Divided pixel clock |
| pix_col_o | output | 10 | Current pixel column counter |
| pix_row_o | output | 10 | Current pixel row counter |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| red_o | output | 3 | Red level |
| green_o | output | 3 | Green level |
| blue_o | output | 2 | Blue level |

## Verification
The bench runs the block with shrunken timing parameters and compares every pixel of several whole frames against an arithmetic model.

- **Blank frame after reset:** shows that reset fills the window with the blank code and keeps every pixel dark.
- **Codes 0–7, then codes 8–15:** the two following frames each load a different set of codes, each under a different foreground colour. Between them they reach every digit glyph, the letter glyph and every blank code. The distinct colours separate the red, green and blue bit slices.
- **Out-of-range writes:** one of these writes targets an index that aliases onto a real cell if the range check is lost, so a missing check shows up as a wrong glyph in that cell.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int CODE_W   = 4;
    localparam int GLYPH_W  = 6;
    localparam int FONT_DIM = 8;

    localparam logic [GLYPH_W-1:0] GLYPH_BLANK  = 6'd0;
    localparam logic [GLYPH_W-1:0] GLYPH_LETTER = 6'd1;
    localparam logic [GLYPH_W-1:0] GLYPH_DIGIT0 = 6'd48;

    // control bits that travel alongside the pixel pipeline
    typedef struct packed {
        logic       vis;
        logic       hs_n;
        logic       vs_n;
        logic       win;
        logic [2:0] frow;
        logic [2:0] fcol;
    } pix_ctl_t;

    localparam pix_ctl_t PIX_CTL_IDLE = '{vis: 1'b0, hs_n: 1'b1, vs_n: 1'b1,
                                          win: 1'b0, frow: 3'd0, fcol: 3'd0};

    // segment masks, bit0 = top bar ... bit6 = middle bar
    function automatic logic [6:0] seg_mask(input logic [3:0] d);
        case (d)
            4'd0:    seg_mask = 7'h3F;
            4'd1:    seg_mask = 7'h06;
            4'd2:    seg_mask = 7'h5B;
            4'd3:    seg_mask = 7'h4F;
            4'd4:    seg_mask = 7'h66;
            4'd5:    seg_mask = 7'h6D;
            4'd6:    seg_mask = 7'h7D;
            4'd7:    seg_mask = 7'h07;
            4'd8:    seg_mask = 7'h7F;
            4'd9:    seg_mask = 7'h6F;
            default: seg_mask = 7'h00;
        endcase
    endfunction

    function automatic logic [GLYPH_W-1:0] code_to_glyph(input logic [CODE_W-1:0] code);
        if (code <= 4'd9)       code_to_glyph = GLYPH_DIGIT0 + {2'b00, code};
        else if (code == 4'd10) code_to_glyph = GLYPH_LETTER;
        else                    code_to_glyph = GLYPH_BLANK;
    endfunction

    function automatic logic [FONT_DIM-1:0] glyph_row(input logic [GLYPH_W-1:0] g,
                                                      input logic [2:0] r);
        logic [6:0] s;
        glyph_row = 8'h00;
        if (g == GLYPH_LETTER) begin
            case (r)
                3'd0:    glyph_row = 8'h18;
                3'd1:    glyph_row = 8'h3C;
                3'd3:    glyph_row = 8'h7E;
                3'd7:    glyph_row = 8'h00;
                default: glyph_row = 8'h66;
            endcase
        end else if (g >= GLYPH_DIGIT0 && g <= GLYPH_DIGIT0 + 6'd9) begin
            s = seg_mask(4'(g - GLYPH_DIGIT0));
            case (r)
                3'd0:       glyph_row = s[0] ? 8'h3C : 8'h00;
                3'd1, 3'd2: glyph_row = (s[5] ? 8'h20 : 8'h00) | (s[1] ? 8'h04 : 8'h00);
                3'd3:       glyph_row = s[6] ? 8'h3C : 8'h00;
                3'd4, 3'd5: glyph_row = (s[4] ? 8'h20 : 8'h00) | (s[2] ? 8'h04 : 8'h00);
                3'd6:       glyph_row = s[3] ? 8'h3C : 8'h00;
                default:    glyph_row = 8'h00;
            endcase
        end
    endfunction

endpackage

// File: rtl/txd_clk_div.sv
module txd_clk_div (
    input  logic clk_i,
    input  logic rst_ni,
    output logic pix_en_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = ~en_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= en_d;
    end

    assign pix_en_o = en_q;
endmodule

// File: rtl/txd_timing.sv
module txd_timing #(
    parameter int CNT_W   = 10,
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 525
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pix_en_i,
    output logic [CNT_W-1:0] col_o,
    output logic [CNT_W-1:0] row_o
);
    typedef struct packed {
        logic [CNT_W-1:0] col;
        logic [CNT_W-1:0] row;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (pix_en_i) begin
            if (cnt_q.col == CNT_W'(H_TOTAL - 1)) begin
                cnt_d.col = '0;
                if (cnt_q.row == CNT_W'(V_TOTAL - 1)) cnt_d.row = '0;
                else                                   cnt_d.row = cnt_q.row + 1'b1;
            end else begin
                cnt_d.col = cnt_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign col_o = cnt_q.col;
    assign row_o = cnt_q.row;
endmodule

// File: rtl/txd_cell_ram.sv
module txd_cell_ram
    import txd_pkg::*;
#(
    parameter int TXT_COLS = 20,
    parameter int TXT_ROWS = 6,
    parameter int ADDR_W   = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_row_i,
    input  logic [ADDR_W-1:0] wr_col_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_row_i,
    input  logic [ADDR_W-1:0] rd_col_i,
    output logic [CODE_W-1:0] rd_code_o
);
    localparam int CELLS = TXT_ROWS * TXT_COLS;
    localparam int IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1;

    typedef struct packed {
        logic [CELLS-1:0][CODE_W-1:0] cells;
        logic [CODE_W-1:0]            rd;
    } ram_st_t;

    ram_st_t st_d, st_q;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             wr_ok, rd_ok;

    always_comb begin
        wr_ok  = (wr_row_i < ADDR_W'(TXT_ROWS)) && (wr_col_i < ADDR_W'(TXT_COLS));
        rd_ok  = (rd_row_i < ADDR_W'(TXT_ROWS)) && (rd_col_i < ADDR_W'(TXT_COLS));
        wr_idx = IDX_W'(int'(wr_row_i) * TXT_COLS + int'(wr_col_i));
        rd_idx = IDX_W'(int'(rd_row_i) * TXT_COLS + int'(rd_col_i));

        st_d = st_q;
        if (wr_en_i && wr_ok) st_d.cells[wr_idx] = wr_code_i;
        if (rd_en_i)          st_d.rd = rd_ok ? st_q.cells[rd_idx] : '1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '1;
        else         st_q <= st_d;
    end

    assign rd_code_o = st_q.rd;
endmodule

// File: rtl/txd_glyph_font.sv
module txd_glyph_font
    import txd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pix_en_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [2:0]        frow_i,
    input  logic [2:0]        fcol_i,
    output logic              dot_o
);
    logic [GLYPH_W-1:0]  glyph_d, glyph_q;
    logic [FONT_DIM-1:0] row_bits;

    always_comb begin
        glyph_d = glyph_q;
        if (pix_en_i) glyph_d = code_to_glyph(code_i);
        row_bits = glyph_row(glyph_q, frow_i);
        dot_o    = row_bits[~fcol_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) glyph_q <= GLYPH_BLANK;
        else         glyph_q <= glyph_d;
    end
endmodule

// File: rtl/txt_display_gen.sv
module txt_display_gen
    import txd_pkg::*;
#(
    parameter int H_VIS    = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_VIS    = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int TXT_COLS = 20,
    parameter int TXT_ROWS = 6,
    parameter int ADDR_W   = 6,
    parameter int CNT_W    = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_row_i,
    input  logic [ADDR_W-1:0] wr_col_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic [7:0]        fg_color_i,
    output logic              pix_clk_o,
    output logic [CNT_W-1:0]  pix_col_o,
    output logic [CNT_W-1:0]  pix_row_o,
    output logic              hsync_no,
    output logic              vsync_no,
    output logic [2:0]        red_o,
    output logic [2:0]        green_o,
    output logic [1:0]        blue_o
);
    localparam int H_TOTAL  = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL  = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HS_START = H_VIS + H_FP;
    localparam int HS_END   = HS_START + H_SYNC;
    localparam int VS_START = V_VIS + V_FP;
    localparam int VS_END   = VS_START + V_SYNC;
    localparam int WIN_COLS = TXT_COLS * FONT_DIM;
    localparam int WIN_ROWS = TXT_ROWS * FONT_DIM;

    typedef struct packed {
        pix_ctl_t   s1;
        pix_ctl_t   s2;
        logic       hs_n;
        logic       vs_n;
        logic [7:0] rgb;
    } top_st_t;

    localparam top_st_t TOP_RESET = '{s1: PIX_CTL_IDLE, s2: PIX_CTL_IDLE,
                                      hs_n: 1'b1, vs_n: 1'b1, rgb: 8'h00};

    logic              pix_en;
    logic [CNT_W-1:0]  col, row;
    logic [CODE_W-1:0] cell_code;
    logic              dot;
    top_st_t           st_d, st_q;

    txd_clk_div u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pix_en_o (pix_en)
    );

    txd_timing #(.CNT_W(CNT_W), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_timing (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pix_en_i (pix_en),
        .col_o    (col),
        .row_o    (row)
    );

    txd_cell_ram #(.TXT_COLS(TXT_COLS), .TXT_ROWS(TXT_ROWS), .ADDR_W(ADDR_W)) u_ram (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_row_i  (wr_row_i),
        .wr_col_i  (wr_col_i),
        .wr_code_i (wr_code_i),
        .rd_en_i   (pix_en),
        .rd_row_i  (ADDR_W'(row >> 3)),
        .rd_col_i  (ADDR_W'(col >> 3)),
        .rd_code_o (cell_code)
    );

    txd_glyph_font u_font (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pix_en_i (pix_en),
        .code_i   (cell_code),
        .frow_i   (st_q.s2.frow),
        .fcol_i   (st_q.s2.fcol),
        .dot_o    (dot)
    );

    always_comb begin
        st_d = st_q;
        if (pix_en) begin
            // stage 1: decode the raw counters, aligned with the cell read
            st_d.s1.vis  = (col < CNT_W'(H_VIS)) && (row < CNT_W'(V_VIS));
            st_d.s1.win  = (col < CNT_W'(WIN_COLS)) && (row < CNT_W'(WIN_ROWS));
            st_d.s1.hs_n = !((col >= CNT_W'(HS_START)) && (col < CNT_W'(HS_END)));
            st_d.s1.vs_n = !((row >= CNT_W'(VS_START)) && (row < CNT_W'(VS_END)));
            st_d.s1.frow = row[2:0];
            st_d.s1.fcol = col[2:0];
            // stage 2: aligned with the glyph address register
            st_d.s2 = st_q.s1;
            // stage 3: font bit selects the colour
            st_d.hs_n = st_q.s2.hs_n;
            st_d.vs_n = st_q.s2.vs_n;
            st_d.rgb  = (st_q.s2.vis && st_q.s2.win && dot) ? fg_color_i : 8'h00;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= TOP_RESET;
        else         st_q <= st_d;
    end

    assign pix_clk_o = pix_en;
    assign pix_col_o = col;
    assign pix_row_o = row;
    assign hsync_no  = st_q.hs_n;
    assign vsync_no  = st_q.vs_n;
    assign red_o     = st_q.rgb[7:5];
    assign green_o   = st_q.rgb[4:2];
    assign blue_o    = st_q.rgb[1:0];
endmodule

// File: rtl/txd_checker.sv
module txd_checker #(
    parameter int CNT_W   = 10,
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 525
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pix_clk,
    input logic [CNT_W-1:0] col,
    input logic [CNT_W-1:0] row,
    input logic             hs_n,
    input logic             vs_n,
    input logic [7:0]       rgb
);
    AST_PIXCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (pix_clk != $past(pix_clk))); // R1

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pix_clk |=> ($stable(col) && $stable(row))); // R1

    AST_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        col < CNT_W'(H_TOTAL)); // R2

    AST_ROW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        row < CNT_W'(V_TOTAL)); // R2

    AST_COL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pix_clk && col == CNT_W'(H_TOTAL - 1)) |=> (col == '0)); // R2

    AST_DARK_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hs_n || !vs_n) |-> (rgb == 8'h00)); // R5
endmodule

bind txt_display_gen txd_checker #(
    .CNT_W   (CNT_W),
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pix_clk (pix_clk_o),
    .col     (pix_col_o),
    .row     (pix_row_o),
    .hs_n    (hsync_no),
    .vs_n    (vsync_no),
    .rgb     ({red_o, green_o, blue_o})
);

// File: tb/txt_display_gen_tb_top.sv
`timescale 1ns/1ps
module txt_display_gen_tb_top;
    localparam int HV = 40, HF = 2, HS = 4, HB = 2;
    localparam int VV = 20, VF = 1, VS = 2, VB = 1;
    localparam int NC = 4, NR = 2;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_row = '0, wr_col = '0;
    logic [3:0] wr_code = '0;
    logic [7:0] fg = 8'hFF;
    logic       pix_clk_o, hsync_no, vsync_no;
    logic [9:0] pix_col_o, pix_row_o;
    logic [2:0] red_o, green_o;
    logic [1:0] blue_o;

    int n_chk = 0, n_fail = 0;
    bit mon_on = 0, done = 0;
    int phase = 0;
    int exp_cell[NR][NC];
    int sh[4], sv[4];
    int nsamp = 0;

    always #2.5 clk = ~clk;

    txt_display_gen #(
        .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .TXT_COLS(NC), .TXT_ROWS(NR), .ADDR_W(6), .CNT_W(10)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_row_i(wr_row),
        .wr_col_i(wr_col), .wr_code_i(wr_code), .fg_color_i(fg),
        .pix_clk_o(pix_clk_o), .pix_col_o(pix_col_o), .pix_row_o(pix_row_o),
        .hsync_no(hsync_no), .vsync_no(vsync_no),
        .red_o(red_o), .green_o(green_o), .blue_o(blue_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // glyph row byte from the rules in R8, R9, R10
    function automatic int model_row(input int code, input int r);
        int seg[10] = '{'h3F, 'h06, 'h5B, 'h4F, 'h66, 'h6D, 'h7D, 'h07, 'h7F, 'h6F};
        int a[8] = '{'h18, 'h3C, 'h66, 'h7E, 'h66, 'h66, 'h66, 'h00};
        int s;
        if (code == 10) return a[r];
        if (code > 10) return 0;
        s = seg[code];
        case (r)
            0: return ((s >> 0) & 1) ? 'h3C : 0;
            1, 2: return (((s >> 5) & 1) ? 'h20 : 0) | (((s >> 1) & 1) ? 'h04 : 0);
            3: return ((s >> 6) & 1) ? 'h3C : 0;
            4, 5: return (((s >> 4) & 1) ? 'h20 : 0) | (((s >> 2) & 1) ? 'h04 : 0);
            6: return ((s >> 3) & 1) ? 'h3C : 0;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (mon_on) begin
            if (!pix_clk_o) begin
                int h, v, eh, ev, code, bits, ecol, acol;
                bit ehs, evs;
                string tag;
                if (nsamp > 0) begin
                    eh = (sh[0] == HT - 1) ? 0 : sh[0] + 1;
                    ev = (sh[0] == HT - 1) ? ((sv[0] == VT - 1) ? 0 : sv[0] + 1) : sv[0];
                    chk(int'(pix_col_o) == eh, "R2 column", int'(pix_col_o), eh);
                    chk(int'(pix_row_o) == ev, "R2 row", int'(pix_row_o), ev);
                end
                for (int i = 3; i > 0; i--) begin sh[i] = sh[i-1]; sv[i] = sv[i-1]; end
                sh[0] = int'(pix_col_o); sv[0] = int'(pix_row_o);
                acol = int'({red_o, green_o, blue_o});
                if (nsamp < 3) begin
                    ehs = 1; evs = 1; ecol = 0; tag = "R11 pipe";
                end else begin
                    h = sh[3]; v = sv[3];
                    ehs = !(h >= HV + HF && h < HV + HF + HS);
                    evs = !(v >= VV + VF && v < VV + VF + VS);
                    ecol = 0; tag = "R5 outside";
                    if (h < HV && v < VV && h < NC * 8 && v < NR * 8) begin
                        code = exp_cell[v / 8][h / 8];
                        bits = model_row(code, v % 8);
                        if ((bits >> (7 - h % 8)) & 1) ecol = int'(fg);
                        tag = (code <= 9) ? "R8 digit" : (code == 10) ? "R9 letter" : "R10 blank";
                        tag = {tag, (ecol != 0) ? " R4 R6" : " R6"};
                        if (v / 8 == 1 && h / 8 == 0) tag = {tag, " R7"};
                        if (phase == 0) tag = {tag, " R11"};
                    end
                end
                chk(hsync_no == ehs, "R3 hsync", int'(hsync_no), int'(ehs));
                chk(vsync_no == evs, "R3 vsync", int'(vsync_no), int'(evs));
                chk(acol == ecol, tag, acol, ecol);
                nsamp++;
            end else begin
                chk(int'(pix_col_o) == sh[0] && int'(pix_row_o) == sv[0],
                    "R1 hold", int'(pix_col_o), sh[0]);
            end
        end
    end

    task automatic cell_wr(input int r, input int c, input int code);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 6'(r); wr_col = 6'(c); wr_code = 4'(code);
        @(negedge clk);
        wr_en = 1'b0;
        if (r < NR && c < NC) exp_cell[r][c] = code;
    endtask

    task automatic wait_row(input int target);
        do @(negedge clk); while (int'(pix_row_o) != target);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) exp_cell[r][c] = 15;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(hsync_no && vsync_no, "R11 syncs", int'({hsync_no, vsync_no}), 3);
        chk({red_o, green_o, blue_o} == 8'h00, "R11 colour", int'({red_o, green_o, blue_o}), 0);
        chk(pix_col_o == 0 && pix_row_o == 0, "R11 counters", int'(pix_col_o), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_on = 1'b1;
        // frame 0: all blank after reset
        wait_row(VV);
        phase = 1;
        fg = 8'hE5;
        for (int i = 0; i < 8; i++) cell_wr(i / NC, i % NC, i);
        cell_wr(0, NC, 8);   // aliases onto row 1 col 0 without the range check (R7)
        cell_wr(NR, 0, 9);
        cell_wr(63, 63, 10);
        wait_row(0);
        wait_row(VV);
        phase = 2;
        fg = 8'h1B;
        for (int i = 0; i < 8; i++) cell_wr(i / NC, i % NC, 8 + i);
        wait_row(0);
        wait_row(VV);
        mon_on = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end
endmodule